// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is the combinational arithmetic/logic unit of a small single-cycle processor. Two operands and a 3-bit function select go in. A result word and an all-zero flag come out in the same cycle. The unit does bitwise AND, bitwise OR, addition, subtraction and a signed "set if less than" comparison.

Subtraction uses the adder that addition uses. Bit 2 of the select inverts the second operand and also feeds the adder's carry input. The comparison takes the sign bit of that difference and widens it to a full word with zeros. The zero flag looks at the final selected result, not at the adder, so it is valid for every function. There are no carry-out or overflow outputs. Select codes 011, 100 and 101 are unused and their result is unspecified.

Top module: `fivefunc_alu`

## Requirements
- R1: With select 000 the result is the bitwise AND of the two operands.
- R2: With select 001 the result is the bitwise OR of the two operands.
- R3: With select 010 the result is the sum of the operands modulo 2^32. A carry out of bit 31 is dropped.
- R4: With select 110 the result is the first operand minus the second, in two's complement modulo 2^32.
- R5: With select 111, bits 31..1 of the result are 0 and bit 0 equals bit 31 of the difference (first minus second).
- R6: With select 111, when that difference does not overflow, bit 0 is 1 exactly when the first operand is less than the second as signed 32-bit numbers. Equal operands give 0.
- R7: The zero flag is 1 exactly when all 32 result bits are 0. This holds for every select code, the unused ones included.
- R8: The unit holds no state. Both outputs follow a change of the inputs with no clock edge.
- R9: Bit 2 of the select controls both the inversion of the second operand and the adder carry input. Setting it changes an addition into a subtraction of the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| fsel | input | 3 | Function select: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed less-than |
| res_y | output | 32 | Selected result |
| zero_o | output | 1 | High when every bit of res_y is 0 |

## Verification
The zero flag is computed in the same cycle as the arithmetic result, so the two functions that can coincide are the zero flag and subtraction or comparison. Directed pairs with equal operands drive the difference to exactly zero. A comparison with a false outcome yields a zero word. Both are judged by checking that the flag rises together with the result. Randomly drawn operands give the opposite case, where only the low bit of a comparison result is set and the flag must stay low. All of these are checked against models in the bench that use native subtraction and signed comparison. The comparison checks are limited to pairs whose difference does not overflow.

// File: rtl/fivefunc_alu_pkg.sv
package fivefunc_alu_pkg;

  localparam int unsigned ALU_W = 32;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;

  // one-bit full adder: {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    full_add = {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
  endfunction

  // bit 2 of the select turns add into subtract
  function automatic logic wants_invert(input logic [SEL_W-1:0] sel);
    wants_invert = sel[2];
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_in,
  input  logic         invert,
  output logic [W-1:0] b_eff,
  output logic         carry_in
);
  always_comb begin
    b_eff    = invert ? ~b_in : b_in;
    carry_in = invert;
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
  import fivefunc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] fa;
    assign fa         = full_add(x[i], y[i], carry[i]);
    assign sum[i]     = fa[0];
    assign carry[i+1] = fa[1];
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W     = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  localparam int unsigned NCH = (W + CHUNK - 1) / CHUNK;
  localparam int unsigned PADW = NCH * CHUNK;

  logic [PADW-1:0] padded;
  logic [NCH-1:0]  chunk_any;

  assign padded = {{(PADW-W){1'b0}}, val};

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    assign chunk_any[c] = |padded[c*CHUNK +: CHUNK];
  end

  assign is_zero = ~|chunk_any;
endmodule

// File: rtl/fivefunc_alu.sv
module fivefunc_alu
  import fivefunc_alu_pkg::*;
(
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [2:0]  fsel,
  output logic [31:0] res_y,
  output logic        zero_o
);
  localparam int unsigned W = ALU_W;

  logic [W-1:0] b_eff;
  logic         carry_in;
  logic [W-1:0] sum_w;
  logic         slt_bit;
  logic [W-1:0] slt_word;

  alu_operand_prep #(.W(W)) u_prep (
    .b_in    (op_b),
    .invert  (wants_invert(fsel)),
    .b_eff   (b_eff),
    .carry_in(carry_in)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .x  (op_a),
    .y  (b_eff),
    .cin(carry_in),
    .sum(sum_w)
  );

  assign slt_bit  = sum_w[W-1];
  assign slt_word = {{(W-1){1'b0}}, slt_bit};

  always_comb begin
    unique case (fsel[1:0])
      2'b00:   res_y = op_a & b_eff;
      2'b01:   res_y = op_a | b_eff;
      2'b10:   res_y = sum_w;
      default: res_y = slt_word;
    endcase
  end

  alu_zero_detect #(.W(W), .CHUNK(8)) u_zero (
    .val    (res_y),
    .is_zero(zero_o)
  );
endmodule

// File: rtl/fivefunc_alu_checker.sv
module fivefunc_alu_checker (
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [2:0]  fsel,
  input logic [31:0] res_y,
  input logic        zero_o,
  input logic        carry_in,
  input logic [31:0] sum_w
);
  logic [31:0] diff;
  assign diff = op_a - op_b;

  always_comb begin
    if (fsel == 3'b000) AST_AND_RESULT: assert (res_y == (op_a & op_b)); // R1
    if (fsel == 3'b001) AST_OR_RESULT: assert (res_y == (op_a | op_b)); // R2
    if (fsel == 3'b010) AST_ADD_RESULT: assert (res_y == op_a + op_b); // R3
    if (fsel == 3'b110) AST_SUB_RESULT: assert (res_y == diff); // R4
    if (fsel == 3'b111) AST_SLT_UPPER_CLEAR: assert (res_y[31:1] == 31'd0); // R5
    if (fsel == 3'b111) AST_SLT_SIGN: assert (res_y[0] == diff[31]); // R5
    AST_ZERO_FLAG: assert (zero_o == (res_y == 32'd0)); // R7
    if (fsel[2]) AST_SUB_CARRY: assert (carry_in && sum_w == diff); // R9
  end
endmodule

bind fivefunc_alu fivefunc_alu_checker u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .fsel    (fsel),
  .res_y   (res_y),
  .zero_o  (zero_o),
  .carry_in(carry_in),
  .sum_w   (sum_w)
);

// File: tb/test_fivefunc_alu.sv
module test_fivefunc_alu;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  f;
  logic [31:0] y;
  logic        z;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  fivefunc_alu i_fivefunc_alu (.op_a(a), .op_b(b), .fsel(f), .res_y(y), .zero_o(z));

  function automatic logic [31:0] model(input logic [2:0] fs, input logic [31:0] x, input logic [31:0] w);
    case (fs)
      3'b000:  return x & w;
      3'b001:  return x | w;
      3'b010:  return x + w;
      3'b110:  return x - w;
      3'b111:  return ($signed(x) < $signed(w)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit sub_overflows(input logic [31:0] x, input logic [31:0] w);
    logic [31:0] d;
    d = x - w;
    return (x[31] != w[31]) && (d[31] != x[31]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h f=%b)", req, act, exp, a, b, f);
    end
  endtask

  task automatic apply(input logic [2:0] fs, input logic [31:0] x, input logic [31:0] w, input string req);
    logic [31:0] e;
    @(negedge clk);
    f = fs; a = x; b = w;
    #1;
    if (fs == 3'b011 || fs == 3'b100 || fs == 3'b101) begin
      chk("R7 zero on unused code", {31'd0, z}, {31'd0, y == 32'd0});
    end else begin
      e = model(fs, x, w);
      chk(req, y, e);
      chk("R7 zero flag", {31'd0, z}, {31'd0, e == 32'd0});
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [5];
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010; codes[3] = 3'b110; codes[4] = 3'b111;
    a = 0; b = 0; f = 0;
    #5;
    // R8: no clock edge yet, outputs already follow inputs
    chk("R8 initial AND of zeros", y, 32'd0);
    chk("R8 initial zero flag", {31'd0, z}, 32'd1);
    a = 32'hF0F0_1234; b = 32'h0FF0_FF00; f = 3'b001; #1;
    chk("R8 combinational OR", y, 32'hFFF0_FF34);

    apply(3'b000, 32'hFFFF_0000, 32'h0F0F_0F0F, "R1 and");
    apply(3'b000, 32'hAAAA_AAAA, 32'h5555_5555, "R1 and disjoint");
    apply(3'b001, 32'h0000_0000, 32'h0000_0000, "R2 or zero");
    apply(3'b001, 32'h8000_0001, 32'h0000_0100, "R2 or");
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001, "R3 add wrap");
    apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001, "R3 add");
    apply(3'b110, 32'h1234_5678, 32'h1234_5678, "R4 sub equal");
    apply(3'b110, 32'h0000_0000, 32'h0000_0001, "R4 sub borrow");
    apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0001, "R6 slt -1<1");
    apply(3'b111, 32'h0000_0001, 32'hFFFF_FFFF, "R6 slt 1<-1");
    apply(3'b111, 32'h0000_0005, 32'h0000_0005, "R6 slt equal");
    apply(3'b111, 32'h8000_0000, 32'h8000_0001, "R5 slt min");
    // R9: same operands, bit 2 flips add into subtract
    apply(3'b010, 32'd100, 32'd30, "R9 add form");
    apply(3'b110, 32'd100, 32'd30, "R9 sub form");
    apply(3'b011, 32'd7, 32'd9, "");
    apply(3'b100, 32'd0, 32'd0, "");
    apply(3'b101, 32'hFFFF_FFFF, 32'd1, "");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, w;
      logic [2:0] fs;
      x = $urandom; w = (i % 7 == 0) ? x : $urandom;
      fs = codes[$urandom % 5];
      if (fs == 3'b111 && sub_overflows(x, w)) w = x ^ 32'h0000_00FF;
      apply(fs, x, w, fs == 3'b111 ? "R5 R6 random slt" :
                      fs == 3'b110 ? "R4 random sub" :
                      fs == 3'b010 ? "R3 random add" :
                      fs == 3'b001 ? "R2 random or" : "R1 random and");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule